// File: doc/BRIEF.md
# MESI Line-State Controller for a Snooping Bus

This block tracks the coherence state of a small set of cache lines under a four-state invalidation scheme on a shared snooping bus. It accepts read, write and evict requests from its processor, issues read, read-for-ownership and write-back transactions as a bus master, and reacts to the transactions that other masters place on the bus. Data storage, arbitration between masters and the choice of a data supplier among several caches sit outside the block. Only the state bookkeeping and the control signals that move data are inside it.

A line that is missing is filled in the exclusive-clean state when no other cache claims a copy, and in the shared state otherwise. Every snooper drives a wired-OR shared signal during the cycle after a read's address phase, and the requester samples it at the end of that cycle. A line filled exclusive-clean can later be written with no bus traffic at all. That removes the second transaction a read-then-write sequence would otherwise cost in a private-data workload.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and `bus_req_valid`, `shared_out`, `flush_out` and `supply_out` are low.
- R2: A read to a line in S, E or M completes one cycle after acceptance with `cpu_hit` high, reports the unchanged state, and raises no bus request.
- R3: A read to an Invalid line requests BusRd (`bus_req_cmd` 2'b00). The line fills in E when `shared_in` is low in the cycle after the address phase (`bus_req_valid` and `bus_gnt` both high), and in S when it is high. Completion is signalled one cycle after that sampling cycle.
- R4: A write to a line in E or M ends in M with `cpu_hit` high and no bus request.
- R5: A write to a line in S or I requests BusRdX (`bus_req_cmd` 2'b01). It completes in the cycle after the address phase with state M and `cpu_hit` low.
- R6: A snooped BusRd (`snp_cmd` 2'b00) to a line in S, E or M drives `shared_out` high in the following cycle. To an Invalid line it leaves `shared_out` low. A snooped BusRdX never drives `shared_out`.
- R7: A snooped BusRd to an M line raises `flush_out` in the next cycle and leaves the line in S. To an E line it leaves the line in S, does not raise `flush_out`, and raises `supply_out` when the parameter `SUPPLY_ON_E` is 1.
- R8: A snooped BusRdX (`snp_cmd` 2'b01) invalidates the line from any valid state, raising `flush_out` in the next cycle only when the line was M.
- R9: Evicting an S or E line completes silently with state I. Evicting an M line requests a write-back (`bus_req_cmd` 2'b10) and ends in I. If the line stops being M before the grant, the request is withdrawn and the eviction completes with no write-back.
- R10: States are reported on `cpu_resp_state` as I=2'b00, S=2'b01, E=2'b10, M=2'b11. Processor operations on `cpu_req_op` are read=2'b00, write=2'b01, evict=2'b10.
- R11: A snoop to the line being filled that arrives in the fill's sampling cycle is applied after the fill. A snooped BusRd therefore sees the new E copy, asserts `shared_out`, and demotes it to S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | Operation: read, write, evict |
| cpu_req_line | input | IDX_W | Line index of the request |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed request used no bus transaction |
| cpu_resp_state | output | 2 | Line state after the completed request |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | Requested command: BusRd, BusRdX, write-back |
| bus_req_line | output | IDX_W | Line of the requested transaction |
| bus_gnt | input | 1 | Address phase granted this cycle |
| snp_valid | input | 1 | Another master's address phase is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_line | input | IDX_W | Snooped line index |
| shared_in | input | 1 | Wired-OR shared signal as seen on the bus |
| shared_out | output | 1 | This cache's contribution to the shared signal |
| flush_out | output | 1 | This cache must put the dirty line on the bus |
| supply_out | output | 1 | This cache offers a clean exclusive copy |

## Verification
The assertions watch, on every cycle, that `shared_out` and `flush_out` only follow a snooped address phase of the right kind. They also check that a fill sample only follows a granted BusRd, that write and read hits finish a cycle later without the bus, and that an ownership read completes in M. The choice between E and S on a fill, the silent upgrade from E, the withdrawn write-back of a line that lost ownership, and the ordering of a snoop against a fill in the same cycle all depend on multi-step histories. Only the bench's directed scenarios show those behaviours, by reading the resulting state back through later processor requests.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EVICT = 2'b10,
        OP_NOP   = 2'b11
    } cpu_op_e;

    typedef enum logic [1:0] {
        BUS_RD   = 2'b00,
        BUS_RDX  = 2'b01,
        BUS_WB   = 2'b10,
        BUS_NONE = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        F_IDLE   = 2'b00,
        F_BUS    = 2'b01,
        F_SAMPLE = 2'b10
    } req_fsm_e;

    typedef struct packed {
        logic shared;
        logic flush;
        logic supply;
    } snoop_rsp_t;

    // State a line takes after another master's transaction
    function automatic line_state_e snoop_next(line_state_e cur, bus_cmd_e cmd);
        line_state_e nxt;
        nxt = cur;
        case (cmd)
            BUS_RD:  nxt = (cur == ST_I) ? ST_I : ST_S;
            BUS_RDX: nxt = ST_I;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    // Fill state chosen from the sampled wired-OR shared signal
    function automatic line_state_e fill_state(logic shared);
        return shared ? ST_S : ST_E;
    endfunction

    function automatic logic is_valid(line_state_e st);
        return st != ST_I;
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int NUM_LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_line,
    input  line_state_e       upd_state,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [IDX_W-1:0]  snp_line,
    output line_state_e       cur_state [NUM_LINES],
    output line_state_e       eff_state [NUM_LINES]
);

    line_state_e st_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic upd_hit;
        logic snp_hit;

        assign upd_hit = upd_valid && (upd_line == IDX_W'(g));
        assign snp_hit = snp_valid && (snp_line == IDX_W'(g));

        // Own update first, then the snoop, in bus order
        always_comb begin
            eff_state[g] = upd_hit ? upd_state : st_q[g];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g] <= ST_I;
            end else if (snp_hit) begin
                st_q[g] <= snoop_next(eff_state[g], snp_cmd);
            end else begin
                st_q[g] <= eff_state[g];
            end
        end

        assign cur_state[g] = st_q[g];

        // R8
        rdx_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
            (snp_hit && snp_cmd == BUS_RDX) |=> (st_q[g] == ST_I));

        // R7
        rd_demotes_chk: assert property (@(posedge clk) disable iff (rst)
            (snp_hit && snp_cmd == BUS_RD && eff_state[g] != ST_I) |=> (st_q[g] == ST_S));
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter bit SUPPLY_ON_E = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        snp_valid,
    input  bus_cmd_e    snp_cmd,
    input  line_state_e line_eff,
    output logic        shared_out,
    output logic        flush_out,
    output logic        supply_out
);

    snoop_rsp_t rsp_d;
    snoop_rsp_t rsp_q;

    always_comb begin
        rsp_d = '0;
        if (snp_valid) begin
            case (snp_cmd)
                BUS_RD: begin
                    rsp_d.shared = is_valid(line_eff);
                    rsp_d.flush  = (line_eff == ST_M);
                    rsp_d.supply = SUPPLY_ON_E && (line_eff == ST_E);
                end
                BUS_RDX: begin
                    rsp_d.flush  = (line_eff == ST_M);
                end
                default: rsp_d = '0;
            endcase
        end
    end

    // Driven during the cycle after the snooped address phase
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign shared_out = rsp_q.shared;
    assign flush_out  = rsp_q.flush;
    assign supply_out = rsp_q.supply;

    // R6
    shared_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        shared_out |-> $past(snp_valid && snp_cmd == BUS_RD));

    // R8
    flush_after_snoop_chk: assert property (@(posedge clk) disable iff (rst)
        flush_out |-> $past(snp_valid && (snp_cmd == BUS_RD || snp_cmd == BUS_RDX)));

    // R7
    flush_not_supply_chk: assert property (@(posedge clk) disable iff (rst)
        !(flush_out && supply_out));

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  cpu_op_e           cpu_req_op,
    input  logic [IDX_W-1:0]  cpu_req_line,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output line_state_e       cpu_resp_state,
    output logic [IDX_W-1:0]  line_sel,
    input  line_state_e       line_cur,
    output logic              bus_req_valid,
    output bus_cmd_e          bus_req_cmd,
    output logic [IDX_W-1:0]  bus_req_line,
    input  logic              bus_gnt,
    input  logic              shared_in,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_line,
    output line_state_e       upd_state
);

    req_fsm_e         fsm_q, fsm_d;
    logic [IDX_W-1:0] line_q, line_d;
    bus_cmd_e         cmd_q, cmd_d;
    logic             done_q, done_d;
    logic             hit_q, hit_d;
    line_state_e      resp_q, resp_d;
    logic             wb_stale;

    assign cpu_ready    = (fsm_q == F_IDLE);
    assign line_sel     = (fsm_q == F_IDLE) ? cpu_req_line : line_q;
    assign bus_req_cmd  = cmd_q;
    assign bus_req_line = line_q;
    assign upd_line     = line_sel;

    // A write-back loses its reason once the line is no longer dirty
    assign wb_stale      = (cmd_q == BUS_WB) && (line_cur != ST_M);
    assign bus_req_valid = (fsm_q == F_BUS) && !wb_stale;

    always_comb begin
        fsm_d     = fsm_q;
        line_d    = line_q;
        cmd_d     = cmd_q;
        done_d    = 1'b0;
        hit_d     = 1'b0;
        resp_d    = resp_q;
        upd_valid = 1'b0;
        upd_state = line_cur;
        case (fsm_q)
            F_IDLE: begin
                if (cpu_req_valid) begin
                    line_d = cpu_req_line;
                    case (cpu_req_op)
                        OP_READ: begin
                            if (is_valid(line_cur)) begin
                                done_d = 1'b1;
                                hit_d  = 1'b1;
                                resp_d = line_cur;
                            end else begin
                                cmd_d = BUS_RD;
                                fsm_d = F_BUS;
                            end
                        end
                        OP_WRITE: begin
                            if (line_cur == ST_E || line_cur == ST_M) begin
                                upd_valid = 1'b1;
                                upd_state = ST_M;
                                done_d    = 1'b1;
                                hit_d     = 1'b1;
                                resp_d    = ST_M;
                            end else begin
                                cmd_d = BUS_RDX;
                                fsm_d = F_BUS;
                            end
                        end
                        OP_EVICT: begin
                            if (line_cur == ST_M) begin
                                cmd_d = BUS_WB;
                                fsm_d = F_BUS;
                            end else begin
                                upd_valid = 1'b1;
                                upd_state = ST_I;
                                done_d    = 1'b1;
                                hit_d     = 1'b1;
                                resp_d    = ST_I;
                            end
                        end
                        default: begin
                            done_d = 1'b1;
                            hit_d  = 1'b1;
                            resp_d = line_cur;
                        end
                    endcase
                end
            end
            F_BUS: begin
                if (wb_stale) begin
                    upd_valid = 1'b1;
                    upd_state = ST_I;
                    done_d    = 1'b1;
                    hit_d     = 1'b1;
                    resp_d    = ST_I;
                    fsm_d     = F_IDLE;
                end else if (bus_gnt) begin
                    case (cmd_q)
                        BUS_RD: fsm_d = F_SAMPLE;
                        BUS_RDX: begin
                            upd_valid = 1'b1;
                            upd_state = ST_M;
                            done_d    = 1'b1;
                            resp_d    = ST_M;
                            fsm_d     = F_IDLE;
                        end
                        default: begin
                            upd_valid = 1'b1;
                            upd_state = ST_I;
                            done_d    = 1'b1;
                            resp_d    = ST_I;
                            fsm_d     = F_IDLE;
                        end
                    endcase
                end
            end
            F_SAMPLE: begin
                upd_valid = 1'b1;
                upd_state = fill_state(shared_in);
                done_d    = 1'b1;
                resp_d    = fill_state(shared_in);
                fsm_d     = F_IDLE;
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= F_IDLE;
            line_q <= '0;
            cmd_q  <= BUS_NONE;
            done_q <= 1'b0;
            hit_q  <= 1'b0;
            resp_q <= ST_I;
        end else begin
            fsm_q  <= fsm_d;
            line_q <= line_d;
            cmd_q  <= cmd_d;
            done_q <= done_d;
            hit_q  <= hit_d;
            resp_q <= resp_d;
        end
    end

    assign cpu_done       = done_q;
    assign cpu_hit        = hit_q;
    assign cpu_resp_state = resp_q;

    // R3
    sample_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == F_SAMPLE) |-> $past(bus_req_valid && bus_gnt && bus_req_cmd == BUS_RD));

    // R2
    read_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req_valid && cpu_req_op == OP_READ && line_cur != ST_I)
        |=> (cpu_done && cpu_hit && !bus_req_valid && cpu_resp_state == $past(line_cur)));

    // R4
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req_valid && cpu_req_op == OP_WRITE && line_cur == ST_E)
        |=> (cpu_done && cpu_hit && !bus_req_valid && cpu_resp_state == ST_M));

    // R5
    rdx_completes_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_gnt && bus_req_cmd == BUS_RDX)
        |=> (cpu_done && !cpu_hit && cpu_resp_state == ST_M));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter bit SUPPLY_ON_E = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic [1:0]        cpu_req_op,
    input  logic [IDX_W-1:0]  cpu_req_line,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [1:0]        cpu_resp_state,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [IDX_W-1:0]  bus_req_line,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [IDX_W-1:0]  snp_line,
    input  logic              shared_in,
    output logic              shared_out,
    output logic              flush_out,
    output logic              supply_out
);

    localparam int NUM_LINES = 1 << IDX_W;

    line_state_e      cur_state [NUM_LINES];
    line_state_e      eff_state [NUM_LINES];
    logic [IDX_W-1:0] line_sel;
    logic             upd_valid;
    logic [IDX_W-1:0] upd_line;
    line_state_e      upd_state;
    line_state_e      resp_state;
    bus_cmd_e         req_cmd;
    bus_cmd_e         snp_cmd_e;

    assign snp_cmd_e = bus_cmd_e'(snp_cmd);

    mesi_req_fsm #(.IDX_W(IDX_W)) u_req (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_op     (cpu_op_e'(cpu_req_op)),
        .cpu_req_line   (cpu_req_line),
        .cpu_ready      (cpu_ready),
        .cpu_done       (cpu_done),
        .cpu_hit        (cpu_hit),
        .cpu_resp_state (resp_state),
        .line_sel       (line_sel),
        .line_cur       (cur_state[line_sel]),
        .bus_req_valid  (bus_req_valid),
        .bus_req_cmd    (req_cmd),
        .bus_req_line   (bus_req_line),
        .bus_gnt        (bus_gnt),
        .shared_in      (shared_in),
        .upd_valid      (upd_valid),
        .upd_line       (upd_line),
        .upd_state      (upd_state)
    );

    mesi_line_array #(.IDX_W(IDX_W)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_line  (upd_line),
        .upd_state (upd_state),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd_e),
        .snp_line  (snp_line),
        .cur_state (cur_state),
        .eff_state (eff_state)
    );

    mesi_snoop_unit #(.SUPPLY_ON_E(SUPPLY_ON_E)) u_snoop (
        .clk        (clk),
        .rst        (rst),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd_e),
        .line_eff   (eff_state[snp_line]),
        .shared_out (shared_out),
        .flush_out  (flush_out),
        .supply_out (supply_out)
    );

    assign cpu_resp_state = resp_state;
    assign bus_req_cmd    = req_cmd;

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

    localparam int IDX_W = 3;
    localparam logic [1:0] RD = 2'b00, RDX = 2'b01, WB = 2'b10;
    localparam logic [1:0] OPR = 2'b00, OPW = 2'b01, OPE = 2'b10;
    localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req_valid = 1'b0;
    logic [1:0] cpu_req_op = 2'b00;
    logic [IDX_W-1:0] cpu_req_line = '0;
    logic cpu_ready, cpu_done, cpu_hit;
    logic [1:0] cpu_resp_state;
    logic bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [IDX_W-1:0] bus_req_line;
    logic bus_gnt = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'b00;
    logic [IDX_W-1:0] snp_line = '0;
    logic shared_in = 1'b0;
    logic shared_out, flush_out, supply_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mesi_snoop_ctrl #(.IDX_W(IDX_W), .SUPPLY_ON_E(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_req_line(cpu_req_line),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .cpu_resp_state(cpu_resp_state),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_line(bus_req_line),
        .bus_gnt(bus_gnt),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_line(snp_line),
        .shared_in(shared_in),
        .shared_out(shared_out), .flush_out(flush_out), .supply_out(supply_out)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present a request for one cycle; on return the accept edge has passed
    task automatic cpu_op(logic [1:0] op, int line);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_op    = op;
        cpu_req_line  = IDX_W'(line);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    // Grant the pending request; for BusRd also drive the shared sample cycle
    task automatic bus_phase(string req, logic [1:0] cmd, int line, logic shr);
        chk(req, "bus_req_valid", int'(bus_req_valid), 1);
        chk(req, "bus_req_cmd", int'(bus_req_cmd), int'(cmd));
        chk(req, "bus_req_line", int'(bus_req_line), line);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        if (cmd == RD) begin
            shared_in = shr;
            @(negedge clk);
            shared_in = 1'b0;
        end
    endtask

    task automatic expect_done(string req, int hit, logic [1:0] st);
        chk(req, "cpu_done", int'(cpu_done), 1);
        chk(req, "cpu_hit", int'(cpu_hit), hit);
        chk(req, "cpu_resp_state", int'(cpu_resp_state), int'(st));
    endtask

    // Observe a line's state through a read; an Invalid line refills as S
    task automatic read_expect(string req, int line, logic [1:0] st);
        cpu_op(OPR, line);
        if (st == SI) begin
            bus_phase(req, RD, line, 1'b1);
            expect_done(req, 0, SS);
        end else begin
            chk(req, "no bus on hit", int'(bus_req_valid), 0);
            expect_done(req, 1, st);
        end
    endtask

    task automatic snoop(string req, logic [1:0] cmd, int line, int e_sh, int e_fl, int e_su);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = cmd;
        snp_line  = IDX_W'(line);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(req, "shared_out", int'(shared_out), e_sh);
        chk(req, "flush_out", int'(flush_out), e_fl);
        chk(req, "supply_out", int'(supply_out), e_su);
    endtask

    task automatic t_reset();
        chk("R1", "cpu_ready", int'(cpu_ready), 1);
        chk("R1", "bus_req_valid", int'(bus_req_valid), 0);
        chk("R1", "shared_out", int'(shared_out), 0);
        chk("R1", "flush_out", int'(flush_out), 0);
        chk("R1", "supply_out", int'(supply_out), 0);
        read_expect("R1", 7, SI);
    endtask

    task automatic t_fill_exclusive_then_write();
        cpu_op(OPR, 0);
        bus_phase("R3", RD, 0, 1'b0);
        expect_done("R3", 0, SE);
        chk("R10", "E code", int'(cpu_resp_state), 2);
        cpu_op(OPW, 0);
        chk("R4", "no bus on E write", int'(bus_req_valid), 0);
        expect_done("R4", 1, SM);
        read_expect("R2", 0, SM);
    endtask

    task automatic t_fill_shared_then_write();
        cpu_op(OPR, 1);
        bus_phase("R3", RD, 1, 1'b1);
        expect_done("R3", 0, SS);
        read_expect("R2", 1, SS);
        cpu_op(OPW, 1);
        bus_phase("R5", RDX, 1, 1'b0);
        expect_done("R5", 0, SM);
        cpu_op(OPW, 2);
        bus_phase("R5", RDX, 2, 1'b0);
        expect_done("R5", 0, SM);
    endtask

    task automatic t_snoop_reads();
        snoop("R7", RD, 0, 1, 1, 0);
        read_expect("R7", 0, SS);
        cpu_op(OPR, 3);
        bus_phase("R3", RD, 3, 1'b0);
        expect_done("R3", 0, SE);
        snoop("R7", RD, 3, 1, 0, 1);
        read_expect("R7", 3, SS);
        snoop("R6", RD, 4, 0, 0, 0);
        read_expect("R6", 4, SI);
    endtask

    task automatic t_snoop_rdx();
        snoop("R8", RDX, 1, 0, 1, 0);
        read_expect("R8", 1, SI);
        snoop("R8", RDX, 1, 0, 0, 0);
        read_expect("R8", 1, SI);
    endtask

    task automatic t_evict();
        cpu_op(OPE, 3);
        chk("R9", "no bus on S evict", int'(bus_req_valid), 0);
        expect_done("R9", 1, SI);
        read_expect("R9", 3, SI);
        cpu_op(OPE, 2);
        bus_phase("R9", WB, 2, 1'b0);
        expect_done("R9", 0, SI);
        read_expect("R9", 2, SI);
    endtask

    task automatic t_evict_cancelled();
        cpu_op(OPW, 5);
        bus_phase("R5", RDX, 5, 1'b0);
        expect_done("R5", 0, SM);
        cpu_op(OPE, 5);
        chk("R9", "wb requested", int'(bus_req_valid), 1);
        chk("R9", "wb cmd", int'(bus_req_cmd), int'(WB));
        snoop("R9", RD, 5, 1, 1, 0);
        chk("R9", "wb withdrawn", int'(bus_req_valid), 0);
        @(negedge clk);
        expect_done("R9", 1, SI);
        read_expect("R9", 5, SI);
    endtask

    task automatic t_snoop_during_fill();
        cpu_op(OPR, 6);
        chk("R11", "bus_req_valid", int'(bus_req_valid), 1);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt   = 1'b0;
        shared_in = 1'b0;
        snp_valid = 1'b1;
        snp_cmd   = RD;
        snp_line  = IDX_W'(6);
        @(negedge clk);
        snp_valid = 1'b0;
        expect_done("R11", 0, SE);
        chk("R11", "shared_out", int'(shared_out), 1);
        chk("R11", "supply_out", int'(supply_out), 1);
        read_expect("R11", 6, SS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_exclusive_then_write();
        t_fill_shared_then_write();
        t_snoop_reads();
        t_snoop_rdx();
        t_evict();
        t_evict_cancelled();
        t_snoop_during_fill();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule